// File: doc/BRIEF.md
# Hot-Plug Event Notification Steering

This block sits between the hot-plug controllers of several downstream switch ports and the switch's interrupt generators. Each port owns one steering bit. When the bit is clear, the port's hot-plug events go out on the standard path as an interrupt request, or as a wake request while the port is in D3hot. When the bit is set, those events are held back from the standard path. Instead they latch a sticky per-port status bit, and the status bit drives one shared general-purpose event line. Only ports strapped into partition 0 may be steered. Every other port ignores its steering bit.

Software reaches two registers through a small register port. The first is the steering register, which is read/write. The second is the status register, which is write-1-to-clear. The shared event line reaches the GPIO pin only when that pin is switched to its alternate function. Interrupt requests from other sources pass through to the same request outputs unchanged.

Top module: `hp_evt_steer`

## Requirements
- R1: After a synchronous active-low reset, the steering register and the status register read 0, `gpe_out` is 0, and no request output is active.
- R2: A port's hot-plug event is the rising edge of `hp_cond`. A level held high yields one event only, in the cycle of the rise.
- R3: An event on a steered port sets that port's status bit at the next clock edge. In that cycle, the port's bits of `irq_req` and `pme_req` stay low unless its `misc_irq` bit is high.
- R4: An event on an unsteered port drives that port's `irq_req` bit high in the same cycle. It never sets the port's status bit.
- R5: A port is steered only when its steering bit is 1 and its `port_part0` bit is 1. A port outside partition 0 always uses the standard path.
- R6: Writing the status register (`reg_addr`=1) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R7: When an event on a steered port and a clear of that port's status bit fall in the same cycle, the bit ends up set.
- R8: `gpe_out` is the OR over ports of (status AND steered). Clearing a steering bit leaves its status bit set until software clears it.
- R9: `gpio_pin` equals `gpe_out` when `gpio_alt_en` is 1, and equals `gpio_sw_out` otherwise.
- R10: `irq_req` is the OR of `misc_irq` and the standard-path hot-plug events, so non-hot-plug requests pass through unaffected.
- R11: `pme_req` is high for a port in the cycle of a standard-path event on that port while its `d3hot` bit is 1.
- R12: Writing `reg_addr`=0 loads the steering register. A read at `reg_addr`=0 returns the value written, whatever the partition straps are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_part0 | input | NUM_PORTS | Per-port strap, 1 = port belongs to partition 0 |
| hp_cond | input | NUM_PORTS | Per-port slot status AND enable from the slot logic |
| d3hot | input | NUM_PORTS | Per-port flag, 1 = port is in D3hot |
| misc_irq | input | NUM_PORTS | Non-hot-plug interrupt requests per port |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = steering register, 1 = status register |
| reg_wdata | input | NUM_PORTS | Write data |
| reg_rdata | output | NUM_PORTS | Read data of the register selected by reg_addr |
| irq_req | output | NUM_PORTS | Interrupt requests toward the INTx/MSI generator |
| pme_req | output | NUM_PORTS | Wake requests toward the PME generator |
| gpe_out | output | 1 | Shared general-purpose event line |
| gpio_alt_en | input | 1 | 1 = GPIO pin uses its alternate function |
| gpio_sw_out | input | 1 | Ordinary GPIO output value |
| gpio_pin | output | 1 | Pin output after the function mux |

## Verification
Two things can land on the same status bit in the same cycle: the hardware set from a steered event and the software write-1-to-clear. The bench provokes this by raising `hp_cond` on a port in the very cycle it writes a 1 to that port's status bit, with a neighbouring bit cleared in the same write. It then expects the raced bit to read 1 and the neighbour to read 0. A full sweep over every steering pattern, every event pattern and several partition straps checks, for each combination, the same-cycle request outputs and the status value one edge later, both against a model computed in the bench.

// File: rtl/hp_steer_pkg.sv
package hp_steer_pkg;
  localparam int MAX_PORTS = 16;
  typedef logic [MAX_PORTS-1:0] port_vec_t;

  localparam logic ADDR_CTL = 1'b0;
  localparam logic ADDR_STS = 1'b1;

  // Rising edge of a level vector given its previous sample
  function automatic port_vec_t rise_of(port_vec_t cur, port_vec_t prev);
    return cur & ~prev;
  endfunction

  // Sticky status update: clear first, hardware set wins
  function automatic port_vec_t sticky_next(port_vec_t sts, port_vec_t set_v,
                                            port_vec_t clr_v);
    return (sts & ~clr_v) | set_v;
  endfunction

  // Ports that actually use the shared line
  function automatic port_vec_t steer_mask(port_vec_t ctl, port_vec_t part0);
    return ctl & part0;
  endfunction
endpackage

// File: rtl/hp_edge_det.sv
module hp_edge_det
  import hp_steer_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] cond,
  output logic [NUM_PORTS-1:0] evt
);
  logic [NUM_PORTS-1:0] cond_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cond_q <= '0;
    else        cond_q <= cond;
  end

  port_vec_t rise_w;
  assign rise_w = rise_of(port_vec_t'(cond), port_vec_t'(cond_q));
  assign evt    = rise_w[NUM_PORTS-1:0];

  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_chk
    AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      evt[gi] |=> !evt[gi]); // R2
  end
endmodule

// File: rtl/hp_steer_route.sv
module hp_steer_route
  import hp_steer_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic [NUM_PORTS-1:0] evt,
  input  logic [NUM_PORTS-1:0] ctl,
  input  logic [NUM_PORTS-1:0] part0,
  input  logic [NUM_PORTS-1:0] d3hot,
  input  logic [NUM_PORTS-1:0] misc_irq,
  output logic [NUM_PORTS-1:0] ctl_eff,
  output logic [NUM_PORTS-1:0] evt_gpe,
  output logic [NUM_PORTS-1:0] evt_std,
  output logic [NUM_PORTS-1:0] irq_req,
  output logic [NUM_PORTS-1:0] pme_req
);
  port_vec_t mask_w;
  assign mask_w  = steer_mask(port_vec_t'(ctl), port_vec_t'(part0));
  assign ctl_eff = mask_w[NUM_PORTS-1:0];

  always_comb begin
    evt_gpe = evt & ctl_eff;
    evt_std = evt & ~ctl_eff;
    irq_req = misc_irq | evt_std;
    pme_req = evt_std & d3hot;
  end
endmodule

// File: rtl/hp_gpe_regs.sv
module hp_gpe_regs
  import hp_steer_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_addr,
  input  logic [NUM_PORTS-1:0] reg_wdata,
  input  logic [NUM_PORTS-1:0] evt_gpe,
  input  logic [NUM_PORTS-1:0] ctl_eff,
  output logic [NUM_PORTS-1:0] ctl,
  output logic [NUM_PORTS-1:0] sts,
  output logic [NUM_PORTS-1:0] reg_rdata,
  output logic                 gpe_out
);
  logic [NUM_PORTS-1:0] clr_req;
  logic                 ctl_we;
  port_vec_t            sts_nxt_w;

  assign ctl_we    = reg_wr && (reg_addr == ADDR_CTL);
  assign clr_req   = (reg_wr && (reg_addr == ADDR_STS)) ? reg_wdata : '0;
  assign sts_nxt_w = sticky_next(port_vec_t'(sts), port_vec_t'(evt_gpe),
                                 port_vec_t'(clr_req));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
      sts <= '0;
    end else begin
      if (ctl_we) ctl <= reg_wdata;
      sts <= sts_nxt_w[NUM_PORTS-1:0];
    end
  end

  assign reg_rdata = (reg_addr == ADDR_STS) ? sts : ctl;
  assign gpe_out   = |(sts & ctl_eff);

  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_chk
    AST_STS_ONLY_STEERED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[gi]) |-> $past(evt_gpe[gi])); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_gpe[gi] |=> sts[gi]); // R7
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req[gi] && !evt_gpe[gi]) |=> !sts[gi]); // R6
  end

  AST_GPE_NEEDS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    (sts == '0) |-> !gpe_out); // R8
endmodule

// File: rtl/hp_gpio_mux.sv
module hp_gpio_mux (
  input  logic alt_en,
  input  logic sw_out,
  input  logic alt_val,
  output logic pin
);
  assign pin = alt_en ? alt_val : sw_out;
endmodule

// File: rtl/hp_evt_steer.sv
module hp_evt_steer
  import hp_steer_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] port_part0,
  input  logic [NUM_PORTS-1:0] hp_cond,
  input  logic [NUM_PORTS-1:0] d3hot,
  input  logic [NUM_PORTS-1:0] misc_irq,
  input  logic                 reg_wr,
  input  logic                 reg_addr,
  input  logic [NUM_PORTS-1:0] reg_wdata,
  output logic [NUM_PORTS-1:0] reg_rdata,
  output logic [NUM_PORTS-1:0] irq_req,
  output logic [NUM_PORTS-1:0] pme_req,
  output logic                 gpe_out,
  input  logic                 gpio_alt_en,
  input  logic                 gpio_sw_out,
  output logic                 gpio_pin
);
  initial begin
    if (NUM_PORTS < 2 || NUM_PORTS > MAX_PORTS)
      $error("NUM_PORTS out of supported range");
  end

  // Named internal events, brought out for the assertions
  logic [NUM_PORTS-1:0] hp_evt;
  logic [NUM_PORTS-1:0] ctl_q;
  logic [NUM_PORTS-1:0] sts_q;
  logic [NUM_PORTS-1:0] ctl_eff;
  logic [NUM_PORTS-1:0] evt_gpe;
  logic [NUM_PORTS-1:0] evt_std;

  hp_edge_det #(.NUM_PORTS(NUM_PORTS)) i_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .cond  (hp_cond),
    .evt   (hp_evt)
  );

  hp_steer_route #(.NUM_PORTS(NUM_PORTS)) i_route (
    .evt      (hp_evt),
    .ctl      (ctl_q),
    .part0    (port_part0),
    .d3hot    (d3hot),
    .misc_irq (misc_irq),
    .ctl_eff  (ctl_eff),
    .evt_gpe  (evt_gpe),
    .evt_std  (evt_std),
    .irq_req  (irq_req),
    .pme_req  (pme_req)
  );

  hp_gpe_regs #(.NUM_PORTS(NUM_PORTS)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .evt_gpe   (evt_gpe),
    .ctl_eff   (ctl_eff),
    .ctl       (ctl_q),
    .sts       (sts_q),
    .reg_rdata (reg_rdata),
    .gpe_out   (gpe_out)
  );

  hp_gpio_mux i_gpio (
    .alt_en  (gpio_alt_en),
    .sw_out  (gpio_sw_out),
    .alt_val (gpe_out),
    .pin     (gpio_pin)
  );

  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_chk
    AST_STEERED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_evt[gi] && ctl_q[gi] && port_part0[gi] && !misc_irq[gi])
        |-> (!irq_req[gi] && !pme_req[gi])); // R3
    AST_OUTSIDE_PART0: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_evt[gi] && !port_part0[gi]) |-> irq_req[gi]); // R5
    AST_STD_NO_STS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_std[gi] && !sts_q[gi]) |=> !sts_q[gi]); // R4
    AST_MISC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      misc_irq[gi] |-> irq_req[gi]); // R10
  end

  AST_GPIO_SW: assert property (@(posedge clk) disable iff (!rst_n)
    !gpio_alt_en |-> (gpio_pin == gpio_sw_out)); // R9
endmodule

// File: tb/test_hp_evt_steer.sv
module test_hp_evt_steer;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] port_part0, hp_cond, d3hot, misc_irq, reg_wdata;
  logic         reg_wr, reg_addr, gpio_alt_en, gpio_sw_out;
  logic [N-1:0] reg_rdata, irq_req, pme_req;
  logic         gpe_out, gpio_pin;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hp_evt_steer #(.NUM_PORTS(N)) i_hp_evt_steer (
    .clk(clk), .rst_n(rst_n), .port_part0(port_part0), .hp_cond(hp_cond),
    .d3hot(d3hot), .misc_irq(misc_irq), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .pme_req(pme_req), .gpe_out(gpe_out), .gpio_alt_en(gpio_alt_en),
    .gpio_sw_out(gpio_sw_out), .gpio_pin(gpio_pin)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: inputs were set at a negedge, return at the next negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; port_part0 = '1; hp_cond = '0; d3hot = '0; misc_irq = '0;
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    gpio_alt_en = 1'b0; gpio_sw_out = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    reg_addr = 1'b0; #1; check("R1 ctl after reset", 16'(reg_rdata), 16'h0);
    reg_addr = 1'b1; #1; check("R1 sts after reset", 16'(reg_rdata), 16'h0);
    check("R1 gpe after reset", 16'(gpe_out), 16'h0);
    check("R1 irq after reset", 16'(irq_req), 16'h0);
    check("R1 pme after reset", 16'(pme_req), 16'h0);

    // Sweep: partition straps x steering pattern x event pattern
    for (int pi = 0; pi < 4; pi++) begin
      for (int c = 0; c < 16; c++) begin
        for (int e = 0; e < 16; e++) begin
          logic [N-1:0] p, eff, ev, d3;
          logic         alt, sw;
          p  = (pi == 0) ? 4'hF : (pi == 1) ? 4'h0 : (pi == 2) ? 4'h5 : 4'hA;
          ev = N'(e);
          eff = N'(c) & p;
          d3 = ev ^ 4'h6;
          alt = ev[1]; sw = ev[2];
          port_part0 = p;
          reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = N'(c); hp_cond = '0;
          step();
          reg_addr = 1'b1; reg_wdata = '1;
          step();
          reg_wr = 1'b0; hp_cond = ev; d3hot = d3; misc_irq = '0;
          gpio_alt_en = alt; gpio_sw_out = sw;
          #1;
          check("R4 R5 irq in event cycle", 16'(irq_req), 16'(ev & ~eff));
          check("R11 pme in event cycle", 16'(pme_req), 16'(ev & ~eff & d3));
          step();
          #1;
          check("R2 no repeat while held", 16'(irq_req), 16'h0);
          check("R3 status after event", 16'(reg_rdata), 16'(ev & eff));
          check("R8 gpe line", 16'(gpe_out), 16'(|(ev & eff)));
          check("R9 gpio pin", 16'(gpio_pin), 16'(alt ? |(ev & eff) : sw));
        end
      end
    end

    // R7 set beats clear; R6 neighbour cleared
    port_part0 = 4'hF; hp_cond = '0; gpio_alt_en = 1'b0; d3hot = '0;
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 4'hF; step();
    reg_addr = 1'b1; reg_wdata = 4'hF; step();
    reg_wr = 1'b0; hp_cond = 4'b0011; step();
    hp_cond = 4'b0000; step();
    #1; check("R3 two steered bits set", 16'(reg_rdata), 16'h3);
    hp_cond = 4'b0001; reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 4'b0011;
    step();
    reg_wr = 1'b0; hp_cond = '0; #1;
    check("R7 set wins over clear", 16'(reg_rdata), 16'h1);
    // R6 write of zeros keeps status
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 4'b0000; step();
    reg_wr = 1'b0; #1;
    check("R6 zero write no effect", 16'(reg_rdata), 16'h1);
    check("R8 gpe held by status", 16'(gpe_out), 16'h1);
    // R8 steering bit cleared while status set
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 4'b0000; step();
    reg_wr = 1'b0; reg_addr = 1'b1; #1;
    check("R8 status kept after unsteer", 16'(reg_rdata), 16'h1);
    check("R8 gpe off when unsteered", 16'(gpe_out), 16'h0);
    hp_cond = 4'b0001; #1;
    check("R4 unsteered port uses irq", 16'(irq_req), 16'h1);
    step(); hp_cond = '0; #1;
    check("R4 status unchanged", 16'(reg_rdata), 16'h1);
    reg_wr = 1'b1; reg_wdata = 4'b0001; step();
    reg_wr = 1'b0; #1;
    check("R6 one write clears", 16'(reg_rdata), 16'h0);

    // R12 steering readback outside partition 0
    port_part0 = 4'h0;
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 4'b1010; step();
    reg_wr = 1'b0; #1;
    check("R12 ctl readback", 16'(reg_rdata), 16'hA);
    hp_cond = 4'b1010; #1;
    check("R5 non-part0 ignores ctl", 16'(irq_req), 16'hA);
    step(); hp_cond = '0;

    // R10 passthrough of other sources
    port_part0 = 4'hF; misc_irq = 4'b0101; #1;
    check("R10 misc passthrough", 16'(irq_req), 16'h5);
    check("R10 no pme from misc", 16'(pme_req), 16'h0);
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 4'hF; step();
    reg_wr = 1'b0; misc_irq = 4'b0001; hp_cond = 4'b0011; #1;
    check("R10 misc with steered events", 16'(irq_req), 16'h1);
    step(); hp_cond = '0; misc_irq = '0;

    // R9 alternate function selects shared line
    gpio_alt_en = 1'b1; gpio_sw_out = 1'b0; #1;
    check("R9 pin follows gpe", 16'(gpio_pin), 16'h1);
    gpio_alt_en = 1'b0; #1;
    check("R9 pin follows sw", 16'(gpio_pin), 16'h0);

    finish_run();
  end
endmodule